// File: doc/BRIEF.md
# Logical and Arithmetic Barrel Shifter

This block is the shift unit of an ALU. It moves a data word left or right by any distance from zero up to one less than the word width, and it does so in a single pass through a logarithmic network of fixed-distance shift stages. It never iterates single-bit shifts over several cycles. Left shifts and logical right shifts bring zeros into the vacated positions. The arithmetic right shift copies the sign bit into the vacated high positions. Shifting left arithmetically is not an operation of this unit.

The shift distance comes from one of two sources. The first is a constant field taken from the instruction word. The second is the low-order bits of a register operand, which the datapath slices down to the amount width before they reach the block. A control input picks the source. The network result is captured in a single output register. Decode, amount selection and the stage chain all lie between two clock edges.

Top module: `barrel_shifter`

## Requirements
- R1: While `rst_n` is low, `result_o` is all zeros.
- R2: A result reflects the inputs sampled at one rising clock edge. It appears on `result_o` after that edge and holds until the next edge.
- R3: `op_i` = 2'b00 shifts `data_i` left by the amount, and the vacated low bits are 0.
- R4: `op_i` = 2'b01 shifts `data_i` right by the amount, and the vacated high bits are 0.
- R5: `op_i` = 2'b11 shifts `data_i` right by the amount, and the vacated high bits take the value of `data_i[DATA_W-1]`.
- R6: `op_i` = 2'b10 gives the same result as 2'b01, a logical right shift.
- R7: When `amt_src_i` is 0, the amount is `shamt_i` and `rs_amt_i` has no effect. When `amt_src_i` is 1, the amount is `rs_amt_i` and `shamt_i` has no effect.
- R8: An amount of 0 returns `data_i` unchanged for every operation code.
- R9: The largest amount, DATA_W-1, is reached in one pass. A left shift keeps only the old bit 0, now in the top position. A logical right shift keeps only the old top bit, now in bit 0. An arithmetic right shift fills the whole word with the sign bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 left logical, 01 right logical, 10 right logical, 11 right arithmetic |
| amt_src_i | input | 1 | Amount source: 0 selects the instruction field, 1 selects the register operand |
| shamt_i | input | AMT_W | Constant shift amount from the instruction |
| rs_amt_i | input | AMT_W | Low-order bits of the register operand that supplies a variable amount |
| data_i | input | DATA_W | Word to be shifted |
| result_o | output | DATA_W | Registered shift result |

## Verification
The bench builds two instances. The first uses DATA_W = 8 and AMT_W = 3. At that size every data word, every amount, every operation code and both amount sources can be swept. The unused amount source is driven with a different value on each vector, so the sweep exercises all three stages and every fill pattern. The second instance uses the default 32-bit width. Directed and pseudo-random vectors on it reach the 16-bit stage and the full 31-position shifts, where sign fill and zero fill have to span the whole word.

// File: rtl/barrel_shifter_pkg.sv
package barrel_shifter_pkg;

    typedef enum logic [1:0] {
        SH_LEFT_LOG  = 2'b00,
        SH_RIGHT_LOG = 2'b01,
        SH_RIGHT_ALT = 2'b10,
        SH_RIGHT_AR  = 2'b11
    } shift_op_e;

    typedef struct packed {
        logic go_left;
        logic sign_fill;
    } shift_ctl_t;

    function automatic shift_ctl_t decode_op(input shift_op_e op);
        shift_ctl_t c;
        c.go_left   = (op == SH_LEFT_LOG);
        c.sign_fill = (op == SH_RIGHT_AR);
        return c;
    endfunction

endpackage

// File: rtl/bs_amt_sel.sv
module bs_amt_sel #(
    parameter int AMT_W = 5
) (
    input  logic             use_reg_i,
    input  logic [AMT_W-1:0] field_amt_i,
    input  logic [AMT_W-1:0] reg_amt_i,
    output logic [AMT_W-1:0] amt_o
);

    always_comb begin
        if (use_reg_i) begin
            amt_o = reg_amt_i;
        end else begin
            amt_o = field_amt_i;
        end
    end

endmodule

// File: rtl/bs_stage.sv
module bs_stage #(
    parameter int W    = 32,
    parameter int DIST = 1
) (
    input  logic [W-1:0] a_i,
    input  logic         en_i,
    input  logic         left_i,
    input  logic         fill_i,
    output logic [W-1:0] y_o
);

    always_comb begin
        if (!en_i) begin
            y_o = a_i;
        end else if (left_i) begin
            y_o = {a_i[W-DIST-1:0], {DIST{1'b0}}};
        end else begin
            y_o = {{DIST{fill_i}}, a_i[W-1:DIST]};
        end
    end

endmodule

// File: rtl/bs_core.sv
module bs_core
    import barrel_shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  shift_op_e         op_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    shift_ctl_t        ctl;
    logic              fill_bit;
    logic [DATA_W-1:0] chain [AMT_W+1];

    always_comb begin
        ctl      = decode_op(op_i);
        fill_bit = ctl.sign_fill & data_i[DATA_W-1];
        chain[0] = data_i;
    end

    for (genvar g = 0; g < AMT_W; g++) begin : g_stage
        bs_stage #(
            .W    (DATA_W),
            .DIST (1 << g)
        ) u_stage (
            .a_i    (chain[g]),
            .en_i   (amt_i[g]),
            .left_i (ctl.go_left),
            .fill_i (fill_bit),
            .y_o    (chain[g+1])
        );
    end

    assign data_o = chain[AMT_W];

endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
    import barrel_shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic              amt_src_i,
    input  logic [AMT_W-1:0]  shamt_i,
    input  logic [AMT_W-1:0]  rs_amt_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] result_o
);

    typedef struct packed {
        logic [DATA_W-1:0] result;
    } state_t;

    state_t            st_d, st_q;
    logic [AMT_W-1:0]  amt_sel;
    logic [DATA_W-1:0] net_out;
    shift_op_e         op_dec;

    assign op_dec = shift_op_e'(op_i);

    bs_amt_sel #(
        .AMT_W (AMT_W)
    ) u_amt_sel (
        .use_reg_i   (amt_src_i),
        .field_amt_i (shamt_i),
        .reg_amt_i   (rs_amt_i),
        .amt_o       (amt_sel)
    );

    bs_core #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_core (
        .op_i   (op_dec),
        .amt_i  (amt_sel),
        .data_i (data_i),
        .data_o (net_out)
    );

    always_comb begin
        st_d        = st_q;
        st_d.result = net_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;

    // R8: zero amount returns the sampled word
    assert_zero_amt_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_sel == '0) |=> (result_o == $past(data_i)));

    // R3: a nonzero left shift leaves bit 0 clear
    assert_left_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 2'b00) && (amt_sel != '0)) |=> (result_o[0] == 1'b0));

    // R4 and R6: a nonzero logical right shift leaves the top bit clear
    assert_right_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (((op_i == 2'b01) || (op_i == 2'b10)) && (amt_sel != '0))
        |=> (result_o[DATA_W-1] == 1'b0));

    // R5: arithmetic right keeps the sign
    assert_sign_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b11) |=> (result_o[DATA_W-1] == $past(data_i[DATA_W-1])));

    // R3, R4: logical shifts never create ones
    assert_no_new_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 2'b11) |=> ($countones(result_o) <= $past($countones(data_i))));

    // R1: the result is cleared while reset is held
    always_comb begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (result_o == '0);
        end
    end

endmodule

// File: tb/barrel_shifter_tb.sv
module barrel_shifter_tb;

    logic clk;
    logic rst_n;

    logic [1:0] op8;
    logic       src8;
    logic [2:0] sh8;
    logic [2:0] rs8;
    logic [7:0] d8;
    logic [7:0] r8;

    logic [1:0]  op32;
    logic        src32;
    logic [4:0]  sh32;
    logic [4:0]  rs32;
    logic [31:0] d32;
    logic [31:0] r32;

    int checks;
    int failures;
    bit done;

    barrel_shifter #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op8), .amt_src_i(src8),
        .shamt_i(sh8), .rs_amt_i(rs8), .data_i(d8), .result_o(r8)
    );

    barrel_shifter #(.DATA_W(32)) u_dut_w32 (
        .clk(clk), .rst_n(rst_n), .op_i(op32), .amt_src_i(src32),
        .shamt_i(sh32), .rs_amt_i(rs32), .data_i(d32), .result_o(r32)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [7:0] model8(input logic [1:0] op, input logic [7:0] d,
                                          input logic [2:0] a);
        logic [7:0] r;
        case (op)
            2'b00:   r = d << a;
            2'b11:   r = $signed(d) >>> a;
            default: r = d >> a;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] model32(input logic [1:0] op, input logic [31:0] d,
                                            input logic [4:0] a);
        logic [31:0] r;
        case (op)
            2'b00:   r = d << a;
            2'b11:   r = $signed(d) >>> a;
            default: r = d >> a;
        endcase
        return r;
    endfunction

    function automatic string optag(input logic [1:0] op);
        case (op)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive8(input logic [1:0] op, input logic src, input logic [2:0] a,
                          input logic [7:0] d);
        @(negedge clk);
        op8  = op;
        src8 = src;
        d8   = d;
        if (src) begin
            rs8 = a;
            sh8 = a ^ 3'b101;
        end else begin
            sh8 = a;
            rs8 = a ^ 3'b011;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic run32(input logic [1:0] op, input logic src, input logic [4:0] a,
                         input logic [31:0] d, input string tag);
        @(negedge clk);
        op32  = op;
        src32 = src;
        d32   = d;
        if (src) begin
            rs32 = a;
            sh32 = ~a;
        end else begin
            sh32 = a;
            rs32 = a + 5'd7;
        end
        @(posedge clk);
        #1;
        chk(r32, model32(op, d, a), tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        checks   = 0;
        failures = 0;
        done     = 1'b0;
        rst_n = 1'b0;
        op8 = 2'b11; src8 = 1'b0; sh8 = 3'd1; rs8 = 3'd2; d8 = 8'hA5;
        op32 = 2'b01; src32 = 1'b1; sh32 = 5'd3; rs32 = 5'd4; d32 = 32'hDEADBEEF;
        repeat (3) @(posedge clk);
        #1;
        chk({24'd0, r8}, 32'd0, "R1 reset w8");
        chk(r32, 32'd0, "R1 reset w32");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: latency and hold between edges
        drive8(2'b00, 1'b0, 3'd2, 8'h13);
        chk({24'd0, r8}, {24'd0, 8'h4C}, "R2 first result");
        @(negedge clk);
        d8 = 8'hF0; op8 = 2'b01;
        #1;
        chk({24'd0, r8}, {24'd0, 8'h4C}, "R2 holds until edge");
        @(posedge clk);
        #1;
        chk({24'd0, r8}, {24'd0, 8'h3C}, "R2 next result");

        // exhaustive sweep on 8-bit instance: R3 R4 R5 R6 R7 R8 R9
        for (int op = 0; op < 4; op++) begin
            for (int src = 0; src < 2; src++) begin
                for (int d = 0; d < 256; d++) begin
                    for (int a = 0; a < 8; a++) begin
                        drive8(2'(op), 1'(src), 3'(a), 8'(d));
                        chk({24'd0, r8}, {24'd0, model8(2'(op), 8'(d), 3'(a))},
                            $sformatf("%s%s%s%s w8 op=%0d d=%0d a=%0d", optag(2'(op)),
                                      (src != 0) ? " R7" : "", (a == 0) ? " R8" : "",
                                      (a == 7) ? " R9" : "", op, d, a));
                    end
                end
            end
        end

        // directed 32-bit corners
        run32(2'b11, 1'b0, 5'd31, 32'h80000000, "R9 R5 sra full sign");
        run32(2'b01, 1'b0, 5'd31, 32'h80000001, "R9 R4 srl top to bit0");
        run32(2'b10, 1'b1, 5'd31, 32'hFFFFFFFF, "R9 R6 alt code right");
        run32(2'b00, 1'b1, 5'd31, 32'h00000003, "R9 R3 sll bit0 to top");
        run32(2'b11, 1'b1, 5'd16, 32'h8001_2345, "R5 R7 sra by 16");
        run32(2'b11, 1'b0, 5'd4,  32'h7FFF_FFF0, "R5 positive sra");
        run32(2'b00, 1'b0, 5'd0,  32'hCAFE_F00D, "R8 sll zero");
        run32(2'b01, 1'b1, 5'd0,  32'hCAFE_F00D, "R8 R7 srl zero");
        run32(2'b11, 1'b0, 5'd0,  32'h8000_0000, "R8 sra zero");
        run32(2'b10, 1'b0, 5'd0,  32'h1234_5678, "R8 R6 alt zero");
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  rop;
            logic [4:0]  ra;
            logic [31:0] rd;
            rop = 2'($urandom_range(0, 3));
            ra  = 5'($urandom_range(0, 31));
            rd  = $urandom;
            run32(rop, 1'(i % 2), ra,
                  rd, $sformatf("%s%s random w32", optag(rop), (i % 2 != 0) ? " R7" : ""));
        end

        finish_run();
    end

endmodule